// File: doc/BRIEF.md
# Page Buffer Write and Merge Engine

This block updates one page of a small on-chip byte array through a page-sized staging buffer. A command opens a sequence by naming a page, a starting byte offset inside that page and one of two update kinds. It then streams data bytes and closes the sequence. Bytes land in the buffer at consecutive offsets from the starting one. The offset wraps inside the page, so a later byte replaces an earlier one at the same offset.

When a sequence that carried at least one byte closes, the block runs an internal cycle and raises `busy` for its whole length. In a page write, every buffer byte that was not supplied is first copied from the stored page. The page is then erased to all ones and programmed from the buffer, so supplied bytes may move bits either way. In a page program, the stored page is ANDed with the buffer, so bits can only be cleared. The internal cycle walks the page one byte per clock in each step and ends with a settle interval of `SETTLE_CYCLES` clocks. A read port with one clock of latency exposes the array. The serial front end and real cell timing sit outside this block.

Top module: `pgbuf_engine`

## Requirements
- R1: After synchronous reset, `busy` is 0 and every array byte reads 8'hFF.
- R2: Data bytes fill the buffer from `cmd_off` at consecutive offsets. After offset 255 the next byte goes to offset 0 of the same page, and a later byte at an offset replaces an earlier one.
- R3: With `cmd_kind` = 1 (page write), each supplied offset of the page ends holding exactly the last byte supplied for it. Each offset not supplied keeps its old value.
- R4: With `cmd_kind` = 0 (page program), each supplied offset ends holding the old value ANDed with the last byte supplied for it. Offsets not supplied are unchanged.
- R5: When a sequence carrying at least one byte closes, `busy` is 1 from the next clock. It stays 1 for 3*256+`SETTLE_CYCLES` clocks for a page write and for 256+`SETTLE_CYCLES` clocks for a page program, then returns to 0.
- R6: A sequence closed with no data byte starts no internal cycle. `busy` stays 0 and the array is unchanged.
- R7: While `busy` is 1, `cmd_start`, `data_valid` and `cmd_end` are ignored.
- R8: An operation changes no byte outside its own page.
- R9: `data_valid` and `cmd_end` have no effect when no sequence is open.
- R10: `rd_data` holds the array byte at address `rd_addr` (page*256+offset) as sampled on the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Opens a sequence (accepted only when idle) |
| cmd_kind | input | 1 | 1 = page write, 0 = page program |
| cmd_page | input | PG_W | Page addressed by the sequence |
| cmd_off | input | 8 | First buffer offset |
| data_valid | input | 1 | Data byte strobe during an open sequence |
| data_byte | input | 8 | Data byte |
| cmd_end | input | 1 | Closes the open sequence |
| rd_addr | input | PG_W+8 | Array read address |
| rd_data | output | 8 | Array read data, one clock latency |
| busy | output | 1 | Internal cycle in progress |

## Verification
The assertions assume that `cmd_start`, `data_valid` and `cmd_end` are single-clock strobes. They also assume that the array and buffer change only through the engine's own phases. Apart from a deliberate burst during `busy`, the stimulus never sends a new start inside an open sequence. Every strobe comes from one task that raises it for exactly one clock and drops it before the next. Sequences that carry data and the close strobe never share a cycle, so the count of supplied bytes stays unambiguous.

// File: rtl/pgbuf_pkg.sv
`timescale 1ns/1ps
package pgbuf_pkg;
    localparam int PAGE_BYTES = 256;
    localparam int OFF_W      = $clog2(PAGE_BYTES);

    typedef logic [7:0] byte_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD,
        PH_MERGE,
        PH_ERASE,
        PH_PROG,
        PH_SETTLE
    } phase_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_WRITE   = 1'b1
    } op_e;

    typedef struct packed {
        logic             we;
        logic [OFF_W-1:0] off;
        byte_t            data;
    } load_t;

    function automatic logic phase_busy(phase_e p);
        return (p == PH_MERGE) || (p == PH_ERASE) || (p == PH_PROG) || (p == PH_SETTLE);
    endfunction

    function automatic byte_t clear_only(byte_t old_v, byte_t new_v);
        return old_v & new_v;
    endfunction
endpackage

// File: rtl/pgbuf_seq.sv
`timescale 1ns/1ps
module pgbuf_seq
    import pgbuf_pkg::*;
#(
    parameter int PG_W          = 2,
    parameter int SETTLE_CYCLES = 4,
    localparam int CNT_W        = $clog2(SETTLE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_start,
    input  logic             cmd_kind,
    input  logic [PG_W-1:0]  cmd_page,
    input  logic [OFF_W-1:0] cmd_off,
    input  logic             data_valid,
    input  byte_t            data_byte,
    input  logic             cmd_end,
    output phase_e           phase,
    output logic [OFF_W-1:0] idx,
    output logic [PG_W-1:0]  page,
    output load_t            ld,
    output logic             clr,
    output logic             busy
);
    logic [OFF_W-1:0] off_q;
    op_e              op_q;
    logic             got_q;
    logic [CNT_W-1:0] scnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            page  <= '0;
            off_q <= '0;
            op_q  <= OP_PROGRAM;
            got_q <= 1'b0;
            scnt  <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: if (cmd_start) begin
                    phase <= PH_LOAD;
                    page  <= cmd_page;
                    off_q <= cmd_off;
                    op_q  <= op_e'(cmd_kind);
                    got_q <= 1'b0;
                end
                PH_LOAD: begin
                    if (data_valid) begin
                        off_q <= off_q + 1'b1;
                        got_q <= 1'b1;
                    end
                    if (cmd_end) begin
                        idx <= '0;
                        if (got_q || data_valid)
                            phase <= (op_q == OP_WRITE) ? PH_MERGE : PH_PROG;
                        else
                            phase <= PH_IDLE;
                    end
                end
                PH_MERGE: begin
                    idx <= idx + 1'b1;
                    if (&idx) phase <= PH_ERASE;
                end
                PH_ERASE: begin
                    idx <= idx + 1'b1;
                    if (&idx) phase <= PH_PROG;
                end
                PH_PROG: begin
                    idx <= idx + 1'b1;
                    if (&idx) begin
                        phase <= PH_SETTLE;
                        scnt  <= '0;
                    end
                end
                PH_SETTLE: begin
                    if (scnt == CNT_W'(SETTLE_CYCLES - 1)) phase <= PH_IDLE;
                    else scnt <= scnt + 1'b1;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        ld.we   = (phase == PH_LOAD) && data_valid;
        ld.off  = off_q;
        ld.data = data_byte;
        clr     = (phase == PH_IDLE) && cmd_start;
        busy    = phase_busy(phase);
    end

    // R5: a close that carried data starts the internal cycle on the next clock
    a_r5_busy_after_close: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && cmd_end && (got_q || data_valid)) |=> busy);

    // R6: an empty close returns to idle without busy
    a_r6_empty_close_idle: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && cmd_end && !got_q && !data_valid) |=> (phase == PH_IDLE && !busy));

    // R7: busy can only begin from an open sequence
    a_r7_busy_from_load: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(phase) == PH_LOAD);

    // R5: each walk step begins at offset zero
    a_r5_erase_starts_zero: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_ERASE && $past(phase) == PH_MERGE) |-> idx == '0);
endmodule

// File: rtl/pgbuf_buffer.sv
`timescale 1ns/1ps
module pgbuf_buffer
    import pgbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  load_t            ld,
    input  logic [OFF_W-1:0] idx,
    input  logic             mrg_we,
    input  byte_t            mrg_data,
    output byte_t            rd_data
);
    byte_t                 buf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < PAGE_BYTES; i++) buf_q[i] <= 8'hFF;
            vld <= '0;
        end else begin
            if (ld.we) begin
                buf_q[ld.off] <= ld.data;
                vld[ld.off]   <= 1'b1;
            end
            if (mrg_we && !vld[idx]) buf_q[idx] <= mrg_data;
        end
    end

    assign rd_data = buf_q[idx];

    // R2: a loaded byte is held and marked as supplied
    a_r2_load_marks_valid: assert property (@(posedge clk) disable iff (rst)
        ld.we |=> (vld[$past(ld.off)] && buf_q[$past(ld.off)] == $past(ld.data)));

    // R3: merging never overwrites a supplied byte
    a_r3_merge_keeps_supplied: assert property (@(posedge clk) disable iff (rst)
        (mrg_we && vld[idx]) |=> buf_q[$past(idx)] == $past(rd_data));
endmodule

// File: rtl/pgbuf_array.sv
`timescale 1ns/1ps
module pgbuf_array
    import pgbuf_pkg::*;
#(
    parameter int PAGES   = 4,
    parameter int PG_W    = 2,
    localparam int ADDR_W = PG_W + OFF_W,
    localparam int DEPTH  = PAGES * PAGE_BYTES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PG_W-1:0]   page,
    input  logic [OFF_W-1:0]  idx,
    input  logic              erase_we,
    input  logic              prog_we,
    input  byte_t             prog_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output byte_t             cur_data,
    output byte_t             rd_data
);
    byte_t             mem [DEPTH];
    logic [ADDR_W-1:0] waddr;

    assign waddr    = {page, idx};
    assign cur_data = mem[waddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            rd_data <= 8'hFF;
        end else begin
            if (erase_we)     mem[waddr] <= 8'hFF;
            else if (prog_we) mem[waddr] <= clear_only(mem[waddr], prog_data);
            rd_data <= mem[rd_addr];
        end
    end

    // R4: a program step never raises a bit
    a_r4_prog_only_clears: assert property (@(posedge clk) disable iff (rst)
        prog_we |=> (mem[$past(waddr)] & ~$past(cur_data)) == 8'h00);

    // R3: an erase step leaves the byte all ones
    a_r3_erase_all_ones: assert property (@(posedge clk) disable iff (rst)
        erase_we |=> mem[$past(waddr)] == 8'hFF);

    // R3: erase and program never act in the same cycle
    a_r3_one_write_kind: assert property (@(posedge clk) disable iff (rst)
        !(erase_we && prog_we));
endmodule

// File: rtl/pgbuf_engine.sv
`timescale 1ns/1ps
module pgbuf_engine
    import pgbuf_pkg::*;
#(
    parameter int  PAGES         = 4,
    parameter int  SETTLE_CYCLES = 4,
    localparam int PG_W          = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int ADDR_W        = PG_W + 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic              cmd_kind,
    input  logic [PG_W-1:0]   cmd_page,
    input  logic [7:0]        cmd_off,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    input  logic              cmd_end,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy
);
    phase_e           phase;
    logic [OFF_W-1:0] idx;
    logic [PG_W-1:0]  page;
    load_t            ld;
    logic             clr;
    byte_t            buf_byte;
    byte_t            arr_byte;

    pgbuf_seq #(.PG_W(PG_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_start(cmd_start), .cmd_kind(cmd_kind), .cmd_page(cmd_page), .cmd_off(cmd_off),
        .data_valid(data_valid), .data_byte(data_byte), .cmd_end(cmd_end),
        .phase(phase), .idx(idx), .page(page), .ld(ld), .clr(clr), .busy(busy)
    );

    pgbuf_buffer u_buf (
        .clk(clk), .rst(rst), .clr(clr), .ld(ld), .idx(idx),
        .mrg_we(phase == PH_MERGE), .mrg_data(arr_byte), .rd_data(buf_byte)
    );

    pgbuf_array #(.PAGES(PAGES), .PG_W(PG_W)) u_arr (
        .clk(clk), .rst(rst), .page(page), .idx(idx),
        .erase_we(phase == PH_ERASE), .prog_we(phase == PH_PROG), .prog_data(buf_byte),
        .rd_addr(rd_addr), .cur_data(arr_byte), .rd_data(rd_data)
    );
endmodule

// File: tb/pgbuf_engine_tb.sv
`timescale 1ns/1ps
module pgbuf_engine_tb;
    localparam int PAGES  = 4;
    localparam int SETTLE = 4;
    localparam int PB     = 256;
    localparam int DEPTH  = PAGES * PB;

    logic       clk = 1'b0, rst = 1'b1;
    logic       cmd_start = 1'b0, cmd_kind = 1'b0, data_valid = 1'b0, cmd_end = 1'b0;
    logic [1:0] cmd_page = '0;
    logic [7:0] cmd_off = '0, data_byte = '0;
    logic [9:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    int m_mem [DEPTH];
    int m_buf [PB];
    bit m_val [PB];
    int m_busy = 0, m_page = 0, m_off = 0;
    bit m_load = 1'b0, m_got = 1'b0, m_kind = 1'b0;

    pgbuf_engine #(.PAGES(PAGES), .SETTLE_CYCLES(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_kind(cmd_kind), .cmd_page(cmd_page),
        .cmd_off(cmd_off), .data_valid(data_valid), .data_byte(data_byte), .cmd_end(cmd_end),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy)
    );

    always #2.5 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_apply();
        int base = m_page * PB;
        for (int i = 0; i < PB; i++) begin
            if (m_kind) m_mem[base+i] = m_val[i] ? m_buf[i] : m_mem[base+i];
            else        m_mem[base+i] = m_mem[base+i] & m_buf[i];
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
            m_busy = 0;
            m_load = 1'b0;
        end else if (m_busy > 0) begin
            m_busy--;
        end else if (m_load) begin
            if (data_valid) begin
                m_buf[m_off] = data_byte;
                m_val[m_off] = 1'b1;
                m_off = (m_off + 1) % PB;
                m_got = 1'b1;
            end
            if (cmd_end) begin
                m_load = 1'b0;
                if (m_got) begin
                    model_apply();
                    m_busy = m_kind ? 3*PB + SETTLE : PB + SETTLE;
                end
            end
        end else if (cmd_start) begin
            m_load = 1'b1;
            m_got  = 1'b0;
            m_page = cmd_page;
            m_off  = cmd_off;
            m_kind = cmd_kind;
            for (int i = 0; i < PB; i++) begin
                m_buf[i] = 8'hFF;
                m_val[i] = 1'b0;
            end
        end
    endtask

    // one clock: DUT and model take the same inputs, busy compared every cycle (R5/R6/R7)
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R5/R6/R7 busy", int'(busy), int'(m_busy > 0));
        cmd_start  = 1'b0;
        cmd_end    = 1'b0;
        data_valid = 1'b0;
    endtask

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((seed * 73 + i * 29 + (i >> 3) * 5) ^ (seed << 2));
    endfunction

    task automatic send_seq(bit kind, int page, int off, int n, int seed);
        cmd_start = 1'b1; cmd_kind = kind; cmd_page = 2'(page); cmd_off = 8'(off);
        step();
        for (int i = 0; i < n; i++) begin
            data_valid = 1'b1;
            data_byte  = pat(seed, i);
            step();
        end
        cmd_end = 1'b1;
        step();
    endtask

    task automatic wait_idle();
        while (m_busy > 0) step();
    endtask

    task automatic read_check(int addr, string tag);
        rd_addr = 10'(addr);
        step();
        check(tag, int'(rd_data), m_mem[addr]);
    endtask

    task automatic check_all(string tag);
        for (int a = 0; a < DEPTH; a++) read_check(a, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        rst = 1'b0;
        step();
        check("R1 busy after reset", int'(busy), 0);
        check_all("R1/R10 reset contents");

        // R4: program a full page from the erased state
        send_seq(1'b0, 1, 0, 256, 1);
        wait_idle();
        check_all("R4/R8 full program");

        // R3: page write merges unsupplied bytes and can set bits
        send_seq(1'b1, 1, 10, 5, 2);
        wait_idle();
        check_all("R3/R8 page write merge");

        // R2 and R4: program that wraps past offset 255
        send_seq(1'b0, 1, 250, 10, 3);
        wait_idle();
        check_all("R2/R4 wrapped program");

        // R2 and R3: more than a page of bytes, later ones overwrite
        send_seq(1'b1, 2, 5, 260, 4);
        wait_idle();
        check_all("R2/R3 overflow overwrite");

        // R6: close with no data
        send_seq(1'b1, 3, 0, 0, 0);
        repeat (3) step();
        check("R6 no cycle", int'(busy), 0);
        check_all("R6 empty close");

        // R7: traffic during busy is ignored
        send_seq(1'b1, 0, 0, 3, 5);
        send_seq(1'b0, 3, 0, 8, 6);
        check("R7 still busy", int'(busy), 1);
        wait_idle();
        check_all("R7 inputs while busy");

        // R9: strobes with no open sequence
        for (int i = 0; i < 4; i++) begin
            data_valid = 1'b1;
            data_byte  = 8'h00;
            step();
        end
        cmd_end = 1'b1;
        step();
        check("R9 idle busy", int'(busy), 0);
        check_all("R9 idle data");

        // R10: read latency with a changing address
        read_check(PB + 12, "R10 read latency");
        read_check(2*PB + 7, "R10 read latency");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule